// File: doc/BRIEF.md
# Dual-Level Vectored Interrupt Controller

The block gathers 64 level-sensitive interrupt lines and presents them to a processor as two request outputs. One is a fast request and the other a normal request. Software sets up each line through a 32-bit word-indexed register port. A line can be enabled or disabled on its own by writing its number, or as a group by writing a whole 32-bit half of the enable vector. A type bit steers each line to the fast path or the normal path. Each line has a 4-bit priority. A 5-bit threshold gates the normal path, and software can force the pending vector directly.

Interrupt service uses two vector registers. A read of the normal vector returns the winning normal line and its priority. A read of the fast vector returns the lowest-numbered fast line. Either read also acknowledges the returned line by clearing its pending bit. A line whose input is still high raises its pending bit again one cycle later, so a level that stays asserted is not lost.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Reset clears pending, enable, type, control and every priority field, and sets the mask to 0x1F. Both request outputs are then low and both vector registers read 0xFFFFFFFF.
- R2: A line is active when its pending and enable bits are both 1. `irq_fast_o` is high exactly when some active line has type bit 1. Neither mask nor priority affects it.
- R3: `irq_norm_o` is high when some active line with type 0 has a priority strictly greater than the mask. With mask 0x1F it is high whenever any active type-0 line exists. A priority equal to the mask does not count.
- R4: A write to index 2 sets the enable bit whose number is in data bits [5:0]. A write to index 3 clears that bit. Both indices read zero.
- R5: Index 4 holds enable bits 63..32 and index 5 holds bits 31..0. Index 6 holds type bits 63..32 and index 7 holds bits 31..0. All four are read/write.
- R6: Indices 8..15 are priority words of eight 4-bit fields each. Index 15 covers lines 0..7 and index 8 covers lines 56..63, and line n sits at bits 4*(n%8)+3 .. 4*(n%8).
- R7: A read of index 16 picks the active type-0 line with the highest priority, with ties going to the higher line number, and ignores the mask. It returns (line << 16) | priority and clears that line's pending bit. With no such line it returns 0xFFFFFFFF.
- R8: A read of index 17 returns the lowest-numbered active type-1 line and clears its pending bit. With none it returns 0xFFFFFFFF.
- R9: A write to index 20 replaces pending bits 63..32 and a write to index 21 replaces bits 31..0. Both indices read zero. Indices 18 and 19 read the raw pending bits, high half and low half.
- R10: Indices 22/23 read active type-0 lines and indices 24/25 read active type-1 lines, high half then low half. Writes to indices 16..19 and 22..25 change nothing.
- R11: A control write (index 0) keeps only data bits 24, 22, 21, 20, 19 and 18, and bit 25 always reads 0. A mask write (index 1) keeps data bits [4:0].
- R12: A rising input sets pending, a falling input clears it, and an input held high sets pending again one cycle after an acknowledge. A rise in the same cycle as an acknowledge of that line leaves the pending bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt line levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (vector reads acknowledge) |
| addr_i | input | 5 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_norm_o | output | 1 | Normal request |
| irq_fast_o | output | 1 | Fast request |

## Verification
All state is updated by the clock edge that samples a write, a read acknowledge or an input change. Both request outputs are decoded combinationally from that state, so they are correct right after that one edge. Read data is registered at the edge that samples `rd_en_i` and reflects the state from before that edge. The bench therefore drives every stimulus at a falling edge and samples at the next falling edge. Back-to-back reads are used to see the one-cycle gap between an acknowledge and the re-set of a line that is still high.

// File: rtl/dic_pkg.sv
package dic_pkg;
  // Word indices of the register port
  localparam logic [4:0] IX_CTRL    = 5'd0;
  localparam logic [4:0] IX_MASK    = 5'd1;
  localparam logic [4:0] IX_ENNUM   = 5'd2;
  localparam logic [4:0] IX_DISNUM  = 5'd3;
  localparam logic [4:0] IX_ENHI    = 5'd4;
  localparam logic [4:0] IX_ENLO    = 5'd5;
  localparam logic [4:0] IX_TYHI    = 5'd6;
  localparam logic [4:0] IX_TYLO    = 5'd7;
  localparam logic [4:0] IX_PRI_TOP = 5'd8;
  localparam logic [4:0] IX_PRI_BOT = 5'd15;
  localparam logic [4:0] IX_NVEC    = 5'd16;
  localparam logic [4:0] IX_FVEC    = 5'd17;
  localparam logic [4:0] IX_RAWHI   = 5'd18;
  localparam logic [4:0] IX_RAWLO   = 5'd19;
  localparam logic [4:0] IX_FRCHI   = 5'd20;
  localparam logic [4:0] IX_FRCLO   = 5'd21;
  localparam logic [4:0] IX_NPHI    = 5'd22;
  localparam logic [4:0] IX_NPLO    = 5'd23;
  localparam logic [4:0] IX_FPHI    = 5'd24;
  localparam logic [4:0] IX_FPLO    = 5'd25;

  // Control bits that survive a write: 24, 22, 21, 20, 19, 18
  localparam logic [31:0] CTRL_KEEP = 32'h017C_0000;
  localparam logic [31:0] NO_VECTOR = 32'hFFFF_FFFF;

  // Normal vector word: line number in the upper half, priority in the lower
  function automatic logic [31:0] pack_norm_vec(input logic [31:0] line, input logic [31:0] pri);
    return (line << 16) | pri;
  endfunction

  // Priority word that holds a given line's field, and the index it lives at
  function automatic int unsigned word_of_line(input int unsigned line, input int unsigned per_word);
    return line / per_word;
  endfunction

  function automatic logic [4:0] index_of_word(input int unsigned word);
    return 5'(IX_PRI_BOT - 5'(word));
  endfunction

  // True when a read or write at this index must not alter state
  function automatic logic is_readonly_ix(input logic [4:0] a);
    return (a >= IX_NVEC && a <= IX_RAWLO) || (a >= IX_NPHI && a <= IX_FPLO);
  endfunction
endpackage

// File: rtl/dic_regs.sv
module dic_regs
  import dic_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned MASK_W = 5,
  localparam int unsigned NSRC      = 2 * REG_W,
  localparam int unsigned SRC_IX_W  = $clog2(NSRC),
  localparam int unsigned PER_WORD  = REG_W / PRIO_W,
  localparam int unsigned PWORDS    = NSRC / PER_WORD
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC-1:0]              src_i,
  input  logic                         wr_en_i,
  input  logic [4:0]                   addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  input  logic [NSRC-1:0]              ack_i,
  output logic [NSRC-1:0]              pend_o,
  output logic [NSRC-1:0]              en_o,
  output logic [NSRC-1:0]              type_o,
  output logic [REG_W-1:0]             ctrl_o,
  output logic [MASK_W-1:0]            mask_o,
  output logic [PWORDS-1:0][REG_W-1:0] prio_w_o,
  output logic [NSRC*PRIO_W-1:0]       prio_flat_o
);
  logic [NSRC-1:0] pend_q, en_q, type_q, src_q;
  logic [NSRC-1:0] rose, fell, pend_d, en_d, type_d, num_bit;
  logic [REG_W-1:0]  ctrl_q;
  logic [MASK_W-1:0] mask_q;
  logic [PWORDS-1:0][REG_W-1:0] prio_q;
  logic wr_force_hi, wr_force_lo;

  assign rose        = src_i & ~src_q;
  assign fell        = ~src_i & src_q;
  assign wr_force_hi = wr_en_i && addr_i == IX_FRCHI;
  assign wr_force_lo = wr_en_i && addr_i == IX_FRCLO;
  assign num_bit     = NSRC'(1) << wdata_i[SRC_IX_W-1:0];

  // Pending: acknowledge clears, a held level re-sets, a rise always wins
  always_comb begin
    pend_d = (pend_q & ~ack_i & ~fell) | (src_i & ~ack_i) | rose;
    if (wr_force_hi) pend_d[NSRC-1:REG_W] = wdata_i;
    if (wr_force_lo) pend_d[REG_W-1:0]    = wdata_i;
  end

  always_comb begin
    en_d   = en_q;
    type_d = type_q;
    if (wr_en_i) begin
      case (addr_i)
        IX_ENNUM:  en_d = en_q | num_bit;
        IX_DISNUM: en_d = en_q & ~num_bit;
        IX_ENHI:   en_d[NSRC-1:REG_W] = wdata_i;
        IX_ENLO:   en_d[REG_W-1:0]    = wdata_i;
        IX_TYHI:   type_d[NSRC-1:REG_W] = wdata_i;
        IX_TYLO:   type_d[REG_W-1:0]    = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      type_q <= '0;
      src_q  <= '0;
      ctrl_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      type_q <= type_d;
      src_q  <= src_i;
      if (wr_en_i && addr_i == IX_CTRL) ctrl_q <= wdata_i & CTRL_KEEP;
      if (wr_en_i && addr_i == IX_MASK) mask_q <= wdata_i[MASK_W-1:0];
    end
  end

  // Priority words: index 15 holds lines 0..7, index 8 the top eight
  for (genvar w = 0; w < PWORDS; w++) begin : g_pword
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_q[w] <= '0;
      else if (wr_en_i && addr_i == index_of_word(w))
        prio_q[w] <= wdata_i;
    end
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_pfield
    assign prio_flat_o[n*PRIO_W +: PRIO_W] =
      prio_q[word_of_line(n, PER_WORD)][(n % PER_WORD)*PRIO_W +: PRIO_W];
  end

  assign pend_o   = pend_q;
  assign en_o     = en_q;
  assign type_o   = type_q;
  assign ctrl_o   = ctrl_q;
  assign mask_o   = mask_q;
  assign prio_w_o = prio_q;

  // R4
  en_by_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i == IX_ENNUM |=> en_q[$past(wdata_i[SRC_IX_W-1:0])]);
  // R4
  dis_by_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i == IX_DISNUM |=> !en_q[$past(wdata_i[SRC_IX_W-1:0])]);
  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && is_readonly_ix(addr_i) |=> $stable(en_q) && $stable(type_q) && $stable(mask_q) && $stable(ctrl_q));
  // R11
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && addr_i == IX_MASK |=> mask_q == $past(wdata_i[MASK_W-1:0]));
  // R12
  rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rose != '0) && !wr_force_hi && !wr_force_lo |=> ($past(rose) & ~pend_q) == '0);
endmodule

// File: rtl/dic_norm_pick.sv
module dic_norm_pick #(
  parameter int unsigned NSRC   = 64,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned MASK_W = 5,
  localparam int unsigned SRC_IX_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        act_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [MASK_W-1:0]      mask_i,
  output logic                   found_o,
  output logic [SRC_IX_W-1:0]    idx_o,
  output logic [PRIO_W-1:0]      prio_o,
  output logic                   req_o
);
  logic over;
  logic [PRIO_W-1:0] p;

  // Highest priority wins; ">=" while scanning upward gives ties to the higher line
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    over    = 1'b0;
    p       = '0;
    for (int i = 0; i < NSRC; i++) begin
      p = prio_i[i*PRIO_W +: PRIO_W];
      if (act_i[i]) begin
        if (!found_o || p >= prio_o) begin
          found_o = 1'b1;
          idx_o   = SRC_IX_W'(i);
          prio_o  = p;
        end
        if ({{(MASK_W-PRIO_W){1'b0}}, p} > mask_i) over = 1'b1;
      end
    end
  end

  assign req_o = found_o && (mask_i == '1 || over);

  // R7
  winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> act_i[idx_o] && prio_i[idx_o*PRIO_W +: PRIO_W] == prio_o);
  // R3
  req_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> act_i != '0);
endmodule

// File: rtl/dic_fast_pick.sv
module dic_fast_pick #(
  parameter int unsigned NSRC = 64,
  localparam int unsigned SRC_IX_W = $clog2(NSRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     act_i,
  output logic                found_o,
  output logic [SRC_IX_W-1:0] idx_o
);
  // Scan downward so the lowest set line is the last one written
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        found_o = 1'b1;
        idx_o   = SRC_IX_W'(i);
      end
    end
  end

  // R8
  lowest_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> act_i[idx_o] && ((act_i & ((NSRC'(1) << idx_o) - NSRC'(1))) == '0));
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dic_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned MASK_W = 5,
  localparam int unsigned NSRC     = 2 * REG_W,
  localparam int unsigned SRC_IX_W = $clog2(NSRC),
  localparam int unsigned PWORDS   = NSRC / (REG_W / PRIO_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [4:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_norm_o,
  output logic             irq_fast_o
);
  logic [NSRC-1:0] pend, en, typ, act, nact, fact, ack;
  logic [REG_W-1:0] ctrl, rd_mux, rdata_q;
  logic [MASK_W-1:0] mask;
  logic [PWORDS-1:0][REG_W-1:0] prio_w;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic nfound, ffound, nreq, nvec_rd, fvec_rd;
  logic [SRC_IX_W-1:0] nidx, fidx;
  logic [PRIO_W-1:0] nprio;

  dic_regs #(.REG_W(REG_W), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ack_i(ack), .pend_o(pend), .en_o(en), .type_o(typ),
    .ctrl_o(ctrl), .mask_o(mask), .prio_w_o(prio_w), .prio_flat_o(prio_flat)
  );

  assign act  = pend & en;
  assign nact = act & ~typ;
  assign fact = act & typ;

  dic_norm_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .act_i(nact), .prio_i(prio_flat), .mask_i(mask),
    .found_o(nfound), .idx_o(nidx), .prio_o(nprio), .req_o(nreq)
  );

  dic_fast_pick #(.NSRC(NSRC)) u_fast (
    .clk(clk), .rst_n(rst_n), .act_i(fact), .found_o(ffound), .idx_o(fidx)
  );

  // Acknowledge: a vector read clears the line it reports
  assign nvec_rd = rd_en_i && addr_i == IX_NVEC;
  assign fvec_rd = rd_en_i && addr_i == IX_FVEC;
  assign ack = ((nvec_rd && nfound) ? (NSRC'(1) << nidx) : '0)
             | ((fvec_rd && ffound) ? (NSRC'(1) << fidx) : '0);

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      IX_CTRL:  rd_mux = ctrl;
      IX_MASK:  rd_mux = REG_W'(mask);
      IX_ENHI:  rd_mux = en[NSRC-1:REG_W];
      IX_ENLO:  rd_mux = en[REG_W-1:0];
      IX_TYHI:  rd_mux = typ[NSRC-1:REG_W];
      IX_TYLO:  rd_mux = typ[REG_W-1:0];
      IX_NVEC:  rd_mux = nfound ? pack_norm_vec(32'(nidx), 32'(nprio)) : NO_VECTOR;
      IX_FVEC:  rd_mux = ffound ? REG_W'(fidx) : NO_VECTOR;
      IX_RAWHI: rd_mux = pend[NSRC-1:REG_W];
      IX_RAWLO: rd_mux = pend[REG_W-1:0];
      IX_NPHI:  rd_mux = nact[NSRC-1:REG_W];
      IX_NPLO:  rd_mux = nact[REG_W-1:0];
      IX_FPHI:  rd_mux = fact[NSRC-1:REG_W];
      IX_FPLO:  rd_mux = fact[REG_W-1:0];
      default: begin
        for (int w = 0; w < PWORDS; w++)
          if (addr_i == index_of_word(w)) rd_mux = prio_w[w];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rd_en_i)  rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign irq_norm_o = nreq;
  assign irq_fast_o = |fact;

  // R8
  fast_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fvec_rd && !ffound |=> rdata_o == NO_VECTOR);
  // R7
  norm_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvec_rd && nfound && !src_i[nidx] && !wr_en_i |=> !pend[$past(nidx)]);
  // R3
  norm_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> nfound);
endmodule

// File: tb/dual_irq_ctrl_tb.sv
module dual_irq_ctrl_tb;
  localparam int unsigned REG_W = 32;
  localparam int unsigned NSRC  = 64;
  localparam int unsigned NROWS = 45;

  typedef struct packed {
    logic        is_rd;
    logic [3:0]  req;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
  } row_t;

  // Register walk: writes, then reads with the expected word
  localparam row_t TBL [0:NROWS-1] = '{
    '{1'b0, 4'd4,  5'd2,  32'h0000_0045, 32'h0},         // R4 enable line 5 (bits 5:0)
    '{1'b1, 4'd4,  5'd5,  32'h0, 32'h0000_0020},
    '{1'b1, 4'd4,  5'd2,  32'h0, 32'h0000_0000},
    '{1'b0, 4'd4,  5'd2,  32'h0000_0028, 32'h0},         // R4 enable line 40
    '{1'b1, 4'd4,  5'd4,  32'h0, 32'h0000_0100},
    '{1'b0, 4'd4,  5'd3,  32'h0000_0028, 32'h0},         // R4 disable line 40
    '{1'b1, 4'd4,  5'd4,  32'h0, 32'h0000_0000},
    '{1'b0, 4'd5,  5'd6,  32'h8000_0000, 32'h0},         // R5 line 63 fast
    '{1'b1, 4'd5,  5'd6,  32'h0, 32'h8000_0000},
    '{1'b1, 4'd5,  5'd7,  32'h0, 32'h0000_0000},
    '{1'b0, 4'd5,  5'd5,  32'hFFFF_FFFF, 32'h0},
    '{1'b1, 4'd5,  5'd5,  32'h0, 32'hFFFF_FFFF},
    '{1'b0, 4'd5,  5'd4,  32'h8000_0001, 32'h0},         // R5 enable 32 and 63
    '{1'b1, 4'd5,  5'd4,  32'h0, 32'h8000_0001},
    '{1'b0, 4'd6,  5'd15, 32'h0000_0030, 32'h0},         // R6 line 1 prio 3
    '{1'b0, 4'd6,  5'd8,  32'h7000_0000, 32'h0},         // R6 line 63 prio 7
    '{1'b1, 4'd6,  5'd15, 32'h0, 32'h0000_0030},
    '{1'b1, 4'd6,  5'd8,  32'h0, 32'h7000_0000},
    '{1'b1, 4'd6,  5'd12, 32'h0, 32'h0000_0000},
    '{1'b0, 4'd11, 5'd0,  32'hFFFF_FFFF, 32'h0},         // R11 control keep mask
    '{1'b1, 4'd11, 5'd0,  32'h0, 32'h017C_0000},
    '{1'b0, 4'd11, 5'd1,  32'hFFFF_FFE3, 32'h0},
    '{1'b1, 4'd11, 5'd1,  32'h0, 32'h0000_0003},
    '{1'b0, 4'd9,  5'd20, 32'h8000_0001, 32'h0},         // R9 force high half
    '{1'b1, 4'd9,  5'd18, 32'h0, 32'h8000_0001},
    '{1'b1, 4'd9,  5'd20, 32'h0, 32'h0000_0000},
    '{1'b1, 4'd10, 5'd22, 32'h0, 32'h0000_0001},         // R10 normal pending high
    '{1'b1, 4'd10, 5'd24, 32'h0, 32'h8000_0000},         // R10 fast pending high
    '{1'b0, 4'd9,  5'd21, 32'h0000_0006, 32'h0},
    '{1'b1, 4'd10, 5'd23, 32'h0, 32'h0000_0006},
    '{1'b1, 4'd9,  5'd21, 32'h0, 32'h0000_0000},
    '{1'b0, 4'd10, 5'd18, 32'h0, 32'h0},                 // R10 ignored writes
    '{1'b1, 4'd10, 5'd18, 32'h0, 32'h8000_0001},
    '{1'b0, 4'd10, 5'd22, 32'h0, 32'h0},
    '{1'b1, 4'd10, 5'd22, 32'h0, 32'h0000_0001},
    '{1'b0, 4'd10, 5'd16, 32'h0, 32'h0},
    '{1'b1, 4'd10, 5'd19, 32'h0, 32'h0000_0006},
    '{1'b1, 4'd7,  5'd16, 32'h0, 32'h0001_0003},         // R7 top priority line 1
    '{1'b1, 4'd7,  5'd16, 32'h0, 32'h0020_0000},         // R7 tie 2 vs 32 -> 32
    '{1'b1, 4'd7,  5'd16, 32'h0, 32'h0002_0000},
    '{1'b1, 4'd7,  5'd16, 32'h0, 32'hFFFF_FFFF},
    '{1'b1, 4'd8,  5'd17, 32'h0, 32'h0000_003F},         // R8 fast line 63
    '{1'b1, 4'd8,  5'd17, 32'h0, 32'hFFFF_FFFF},
    '{1'b1, 4'd7,  5'd18, 32'h0, 32'h0000_0000},
    '{1'b1, 4'd7,  5'd19, 32'h0, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [REG_W-1:0] wdata = '0;
  logic [REG_W-1:0] rdata;
  logic irq_norm, irq_fast;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  dual_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_norm_o(irq_norm), .irq_fast_o(irq_fast)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    check("R1 irq_norm", 32'(irq_norm), 0);
    check("R1 irq_fast", 32'(irq_fast), 0);
    rd(5'd1, v);  check("R1 mask", v, 32'h1F);
    rd(5'd0, v);  check("R1 ctrl", v, 0);
    rd(5'd5, v);  check("R1 enable low", v, 0);
    rd(5'd11, v); check("R1 prio word", v, 0);
    rd(5'd16, v); check("R1 normal vector", v, 32'hFFFF_FFFF);
    rd(5'd17, v); check("R1 fast vector", v, 32'hFFFF_FFFF);

    for (int i = 0; i < NROWS; i++) begin
      if (TBL[i].is_rd) begin
        rd(TBL[i].a, v);
        check($sformatf("R%0d row %0d", TBL[i].req, i), v, TBL[i].exp);
      end else begin
        wr(TBL[i].a, TBL[i].d);
      end
    end

    // Request outputs: lines 0..31 and 32,63 enabled, 63 fast, mask 3
    check("R2 idle fast", 32'(irq_fast), 0);
    check("R3 idle norm", 32'(irq_norm), 0);
    wr(5'd21, 32'h2);                       // line 1, prio 3 == mask
    check("R3 prio equal mask", 32'(irq_norm), 0);
    wr(5'd1, 32'h2);
    check("R3 prio above mask", 32'(irq_norm), 1);
    wr(5'd21, 32'h4);                       // line 2, prio 0
    wr(5'd1, 32'h0);
    check("R3 prio 0 mask 0", 32'(irq_norm), 0);
    wr(5'd1, 32'h1F);
    check("R3 open mask", 32'(irq_norm), 1);
    wr(5'd20, 32'h8000_0000);               // line 63 fast
    wr(5'd1, 32'h10);
    check("R2 fast ignores mask", 32'(irq_fast), 1);
    check("R3 mask 0x10 blocks", 32'(irq_norm), 0);
    wr(5'd3, 32'h3F);
    check("R2 fast needs enable", 32'(irq_fast), 0);

    // Level behaviour
    wr(5'd21, 32'h0);
    wr(5'd20, 32'h0);
    src[3] = 1'b1;
    @(negedge clk);
    rd(5'd19, v); check("R12 rise sets", v, 32'h8);
    rd(5'd16, v); check("R12 ack vector", v, 32'h0003_0000);
    rd(5'd19, v); check("R12 cleared by ack", v, 32'h0);
    rd(5'd19, v); check("R12 held level re-sets", v, 32'h8);
    src[3] = 1'b0;
    @(negedge clk);
    rd(5'd19, v); check("R12 fall clears", v, 32'h0);
    wr(5'd21, 32'h20);
    src[5] = 1'b1;
    rd(5'd16, v); check("R12 ack with rise", v, 32'h0005_0000);
    rd(5'd19, v); check("R12 rise beats ack", v, 32'h20);
    src[5] = 1'b0;
    @(negedge clk);

    // Reset again with state loaded
    wr(5'd21, 32'hFFFF_0000);
    do_reset();
    rd(5'd19, v); check("R1 pending cleared", v, 0);
    rd(5'd1, v);  check("R1 mask restored", v, 32'h1F);
    rd(5'd15, v); check("R1 prio cleared", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule